// File: doc/BRIEF.md
# PDM Microphone Capture Front End

This block drives the bit clock for two pulse-density-modulated microphone ports and recovers one left bit and one right bit per bit-clock period from each port's shared data line. The bit clock comes from a single master clock by integer division. The divide ratio is chosen by a small control word, so every rate has a whole number of master cycles in each quarter period. The same word chooses where in the bit-clock period each channel is taken: at an edge, or in the middle of the high or the low phase. It also lets each port copy its left bit onto its right output.

Each port delivers its left and right bits together with a one-cycle valid strobe once per bit-clock period. The strobe comes after the later of the two channels has been taken. The data lines pass through a two-stage synchronizer, and the capture points are shifted by two master cycles to make up for it. A later decimation stage consumes the outputs. Control-word changes that touch the clock or the sample points wait for the next period boundary.

Top module: `pdm_mic_front`

## Requirements
- R1: Control bits [1:0] select the master cycles per bit-clock period: code 0 gives 12, code 1 gives 16, code 2 gives 24 and code 3 gives 48 (4.704, 3.528, 2.352 and 1.176 MHz from a 56.448 MHz master clock).
- R2: The bit clock is high for the first half of every period and low for the second half. A new rate or phase code takes effect only at the next period boundary, so no high or low phase is ever shorter than the current rate's half period.
- R3: A channel "taken at position k" receives the data-line value present at the master-clock edge that starts cycle k of the bit-clock period, where k = 0 is the edge that raises the bit clock. With H the half period and Q the quarter period, control bits [3:2] select left/right positions as follows: code 0 gives 0/H, code 1 gives Q/H+Q, code 2 gives H/0, and code 3 gives H+Q/Q.
- R4: When control bit 4 (port 0) or bit 5 (port 1) is set, that port's right output equals its left output, and its data in the right-channel position has no effect.
- R5: The control word reads back with bits [5:0] as written and every higher bit as zero.
- R6: Each port raises its valid strobe for exactly one master cycle per bit-clock period, two master cycles after the later channel position. The left and right outputs change only together with that strobe.
- R7: While the active-low synchronous reset is asserted, the bit clock is low and all outputs and strobes are zero. After reset the control word reads 2, and the first bit-clock period starts with its high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | CTRL_W | Control word write data |
| cfg_rdata | output | CTRL_W | Control word read data |
| mic_clk | output | 1 | Bit clock to both microphone ports |
| mic_data | input | PORTS | Data line of each port |
| pcm_left | output | PORTS | Left bit of each port |
| pcm_right | output | PORTS | Right bit of each port |
| pcm_valid | output | PORTS | One-cycle strobe per port when new bits are present |

## Verification
The hardest case to reach from the ports is a capture point that is off by one master cycle, or a new code that takes effect in the middle of a period. Neither shows up when the data lines are slow. The bench therefore changes both data lines on every master cycle from independent shift-register sequences, so any misplaced sample picks up a different bit. It issues each control write one master cycle into a period, so a design that applies the write early produces a short period or wrong bits that the scoreboard reports. A reset in the middle of a period, followed by a return to the default rate, covers the restart path.

// File: rtl/pdm_mic_front.sv
module pdm_mic_front #(
  parameter int CTRL_W = 32,
  parameter int PORTS  = 2,
  parameter int DIV_R0 = 12,
  parameter int DIV_R1 = 16,
  parameter int DIV_R2 = 24,
  parameter int DIV_R3 = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  output logic              mic_clk,
  input  logic [PORTS-1:0]  mic_data,
  output logic [PORTS-1:0]  pcm_left,
  output logic [PORTS-1:0]  pcm_right,
  output logic [PORTS-1:0]  pcm_valid
);
  localparam int CFG_W = 4 + PORTS;
  localparam int CNT_W = $clog2(DIV_R3 + 1);
  localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(2);

  typedef logic [CNT_W-1:0] cnt_t;

  function automatic cnt_t div_of(input logic [1:0] code);
    case (code)
      2'd0:    return cnt_t'(DIV_R0);
      2'd1:    return cnt_t'(DIV_R1);
      2'd2:    return cnt_t'(DIV_R2);
      default: return cnt_t'(DIV_R3);
    endcase
  endfunction

  logic [CFG_W-1:0] ctrl;
  logic             act, clk_q;
  cnt_t             ph;
  logic [1:0]       rate_a, phs_a;

  cnt_t       div_a, half_a, qtr_a, ph_n, k_l, k_r;
  logic [1:0] rate_n, phs_n;
  logic       bound, late_left, cap_l, cap_r, cap_early, cap_late;

  assign div_a  = div_of(rate_a);
  assign half_a = div_a >> 1;
  assign qtr_a  = div_a >> 2;
  assign bound  = !act || (ph == div_a - cnt_t'(1));
  assign ph_n   = bound ? '0 : ph + cnt_t'(1);
  assign rate_n = bound ? ctrl[1:0] : rate_a;
  assign phs_n  = bound ? ctrl[3:2] : phs_a;

  always_comb begin
    case (phs_a)
      2'd0:    begin k_l = '0;              k_r = half_a;         end
      2'd1:    begin k_l = qtr_a;           k_r = half_a + qtr_a; end
      2'd2:    begin k_l = half_a;          k_r = '0;             end
      default: begin k_l = half_a + qtr_a;  k_r = qtr_a;          end
    endcase
  end

  assign late_left = phs_a[1];
  assign cap_l     = act && (ph == k_l + cnt_t'(1));
  assign cap_r     = act && (ph == k_r + cnt_t'(1));
  assign cap_early = late_left ? cap_r : cap_l;
  assign cap_late  = late_left ? cap_l : cap_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= CFG_RST;
      act    <= 1'b0;
      ph     <= '0;
      rate_a <= 2'd2;
      phs_a  <= 2'd0;
      clk_q  <= 1'b0;
    end else begin
      if (cfg_we) ctrl <= cfg_wdata[CFG_W-1:0];
      act    <= 1'b1;
      ph     <= ph_n;
      rate_a <= rate_n;
      phs_a  <= phs_n;
      clk_q  <= ph_n < (div_of(rate_n) >> 1);
    end
  end

  assign mic_clk   = clk_q;
  assign cfg_rdata = {{(CTRL_W-CFG_W){1'b0}}, ctrl};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic s1, s2, early_q, l_q, r_q, v_q, left_nx;

    assign left_nx = late_left ? s2 : early_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1      <= 1'b0;
        s2      <= 1'b0;
        early_q <= 1'b0;
        l_q     <= 1'b0;
        r_q     <= 1'b0;
        v_q     <= 1'b0;
      end else begin
        s1  <= mic_data[p];
        s2  <= s1;
        v_q <= cap_late;
        if (cap_early) early_q <= s2;
        if (cap_late) begin
          l_q <= left_nx;
          r_q <= ctrl[4+p] ? left_nx : (late_left ? early_q : s2);
        end
      end
    end

    assign pcm_left[p]  = l_q;
    assign pcm_right[p] = r_q;
    assign pcm_valid[p] = v_q;
  end
endmodule

// File: rtl/pdm_mic_front_chk.sv
module pdm_mic_front_chk #(
  parameter int CTRL_W = 32,
  parameter int PORTS  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] cfg_rdata,
  input logic              mic_clk,
  input logic [PORTS-1:0]  pcm_left,
  input logic [PORTS-1:0]  pcm_right,
  input logic [PORTS-1:0]  pcm_valid
);
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CTRL_W-1:4+PORTS] == '0);

  p_no_short_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mic_clk) |=> mic_clk);

  p_no_short_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mic_clk) |=> !mic_clk);

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_n |=> (!mic_clk && pcm_valid == '0 && pcm_left == '0 && pcm_right == '0));

  for (genvar i = 0; i < PORTS; i++) begin : g_chk
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pcm_valid[i] |=> !pcm_valid[i]);

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pcm_valid[i] |-> ($stable(pcm_left[i]) && $stable(pcm_right[i])));

    p_mono_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pcm_valid[i] && $past(cfg_rdata[4+i])) |-> (pcm_right[i] == pcm_left[i]));
  end
endmodule

bind pdm_mic_front pdm_mic_front_chk #(.CTRL_W(CTRL_W), .PORTS(PORTS)) u_chk (.*);

// File: tb/tb_pdm_mic_front.sv
module tb_pdm_mic_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mic_clk;
  logic [1:0]  mic_data = 2'b00;
  logic [1:0]  pcm_left, pcm_right, pcm_valid;

  always #2 clk = ~clk;

  pdm_mic_front dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .mic_clk(mic_clk), .mic_data(mic_data),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .pcm_valid(pcm_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bdiv(input logic [1:0] c);
    return (c == 2'd0) ? 12 : (c == 2'd1) ? 16 : (c == 2'd2) ? 24 : 48;
  endfunction

  logic [5:0]  shadow = 6'h02;
  logic [5:0]  act_cfg;
  logic [1:0]  q0[$];
  logic [1:0]  q1[$];
  logic        samp0[64];
  logic        samp1[64];
  logic [15:0] lf0 = 16'hACE1, lf1 = 16'h1D2B;
  logic        prev_clk;
  bit          started;
  bit          hold_bad;
  int          pos;
  int          vcnt[2];
  logic        last_l[2], last_r[2];

  // monitor, scoreboard consumer and data-line stimulus
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pos = 0; prev_clk = 1'b0; started = 0; hold_bad = 0;
        q0.delete(); q1.delete();
        for (int p = 0; p < 2; p++) begin vcnt[p] = 0; last_l[p] = 0; last_r[p] = 0; end
      end else begin
        for (int p = 0; p < 2; p++) begin
          if (pcm_valid[p]) begin
            logic [1:0] e;
            vcnt[p]++;
            if ((p == 0 && q0.size() == 0) || (p == 1 && q1.size() == 0)) begin
              chk(0, "R6", "strobe with nothing expected", 1, 0);
            end else begin
              e = (p == 0) ? q0.pop_front() : q1.pop_front();
              chk(pcm_left[p] == e[1], "R3", $sformatf("left port%0d", p), pcm_left[p], e[1]);
              chk(pcm_right[p] == e[0], "R4", $sformatf("right port%0d", p), pcm_right[p], e[0]);
            end
            last_l[p] = pcm_left[p]; last_r[p] = pcm_right[p];
          end else if (pcm_left[p] != last_l[p] || pcm_right[p] != last_r[p]) begin
            hold_bad = 1;
          end
        end
        if (mic_clk && !prev_clk) begin
          if (started) begin
            chk(pos + 1 == bdiv(act_cfg[1:0]), "R1", "period length", pos + 1, bdiv(act_cfg[1:0]));
            for (int p = 0; p < 2; p++)
              chk(vcnt[p] == 1, "R6", $sformatf("strobes per period port%0d", p), vcnt[p], 1);
            chk(!hold_bad, "R6", "outputs held between strobes", hold_bad, 0);
          end
          pos = 0; act_cfg = shadow; started = 1; hold_bad = 0;
          vcnt[0] = 0; vcnt[1] = 0;
        end else begin
          pos++;
        end
        if (started && !mic_clk && prev_clk)
          chk(pos == bdiv(act_cfg[1:0]) / 2, "R2", "high half length", pos, bdiv(act_cfg[1:0]) / 2);
        if (started && pos < 64) begin
          int h, q, kl, kr, late;
          samp0[pos] = mic_data[0];
          samp1[pos] = mic_data[1];
          h = bdiv(act_cfg[1:0]) / 2; q = h / 2;
          case (act_cfg[3:2])
            2'd0: begin kl = 0;     kr = h;     end
            2'd1: begin kl = q;     kr = h + q; end
            2'd2: begin kl = h;     kr = 0;     end
            default: begin kl = h + q; kr = q;  end
          endcase
          late = (kl > kr) ? kl : kr;
          if (pos == late) begin
            logic l, r;
            l = samp0[kl]; r = shadow[4] ? l : samp0[kr];
            q0.push_back({l, r});
            l = samp1[kl]; r = shadow[5] ? l : samp1[kr];
            q1.push_back({l, r});
          end
        end
        prev_clk = mic_clk;
      end
      lf0 = {lf0[14:0], lf0[15] ^ lf0[13] ^ lf0[12] ^ lf0[10]};
      lf1 = {lf1[14:0], lf1[15] ^ lf1[13] ^ lf1[12] ^ lf1[10]};
      mic_data = {lf1[0], lf0[0]};
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    @(posedge mic_clk);
    @(negedge clk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow = v[5:0];
    chk(cfg_rdata == {26'd0, v[5:0]}, "R5", "readback", int'(cfg_rdata), int'(v[5:0]));
  endtask

  task automatic wait_periods(input int n);
    repeat (n) @(posedge mic_clk);
  endtask

  task automatic check_reset_state();
    chk(mic_clk == 1'b0, "R7", "bit clock in reset", mic_clk, 0);
    chk(pcm_valid == 2'b00, "R7", "strobes in reset", pcm_valid, 0);
    chk(pcm_left == 2'b00 && pcm_right == 2'b00, "R7", "samples in reset",
        {pcm_left, pcm_right}, 0);
    chk(cfg_rdata == 32'd2, "R7", "default control word", int'(cfg_rdata), 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state();
    shadow = 6'h02;
    rst_n = 1'b1;
    @(negedge clk);
    chk(mic_clk == 1'b1, "R7", "first half after reset is high", mic_clk, 1);
    wait_periods(4);
    for (int r = 0; r < 4; r++) begin
      for (int ph = 0; ph < 4; ph++) begin
        write_cfg(32'((((r + ph) % 4) << 4) | (ph << 2) | r));
        wait_periods(3);
      end
    end
    write_cfg(32'hFFFF_FFFF);
    wait_periods(3);
    write_cfg(32'h0000_0019);
    wait_periods(3);
    @(posedge mic_clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    shadow = 6'h02;
    rst_n = 1'b1;
    wait_periods(4);
    write_cfg(32'h0000_0030);
    wait_periods(3);
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule